// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block rules on whether a cache-block operation (zeroing a block, cleaning it, flushing it or invalidating it) may go ahead. It receives one request at a time. A request carries the current privilege level, a flag that says whether the hart runs virtualized, the kind of operation, three per-level enable vectors from the environment-configuration state, a byte address, and two permission answers (load allowed, store allowed) from an external translation checker.

One cycle after a request strobe, the block returns a registered verdict and the byte address aligned down to the cache-block boundary. There are four possible verdicts: proceed, illegal-instruction, virtual-instruction, or store fault. The enable gating is checked first, in a fixed order. The memory-permission rule is applied only after the enable gating has passed. The verdict and the address then stay unchanged until the next request arrives.

Top module: `cbo_perm_gate`

## Requirements
- R1: Each enable vector has one bit per operation group: bit 0 gates zero (op code 0), bit 1 gates both clean (op code 1) and flush (op code 2), and bit 2 gates invalidate (op code 3). Bits that do not belong to the requested operation have no effect on the verdict.
- R2: With privilege U (0) or S (1) and the machine-level bit for the operation clear, the verdict is illegal-instruction (code 1), whatever the other inputs are.
- R3: If R2 does not fire and virtualization is on, the verdict is virtual-instruction (code 2) when either of two conditions holds: the privilege is U or S and the hypervisor-level bit is clear, or the privilege is U and the supervisor-level bit is clear.
- R4: If R2 and R3 do not fire, the verdict is illegal-instruction (code 1) when the privilege is U and the supervisor-level bit is clear. Privilege M (3) never receives an enable-gating fault.
- R5: Enable-gating faults take priority over the permission rule. When R2, R3 or R4 fires, the load and store permission inputs do not change the verdict.
- R6: For clean, flush and invalidate, the verdict is proceed (code 0) when load is allowed. When load is not allowed, the verdict is proceed if store is allowed and store fault (code 3) if it is not.
- R7: For zero, the verdict is proceed when store is allowed and store fault when it is not. The load permission input is ignored.
- R8: The returned address equals the request address with its low log2(BLOCK_BYTES) bits cleared. BLOCK_BYTES is a power of two.
- R9: The response-valid output is high for exactly the one cycle after each request strobe. The verdict and the address do not change in any cycle that has no request.
- R10: After reset, response-valid is 0, the verdict is proceed (0) and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_priv | input | 2 | Privilege level: U=0, S=1, M=3 |
| req_virt | input | 1 | Virtualization enabled |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| m_en | input | 3 | Machine-level enable vector |
| h_en | input | 3 | Hypervisor-level enable vector |
| s_en | input | 3 | Supervisor-level enable vector |
| req_addr | input | ADDR_W | Byte address |
| load_ok | input | 1 | Load access allowed by translation |
| store_ok | input | 1 | Store access allowed by translation |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_result | output | 2 | 0 proceed, 1 illegal, 2 virtual, 3 store fault |
| rsp_addr | output | ADDR_W | Block-aligned address |

## Verification
The hardest cases to reach from the ports are those where several fault conditions hold at once and only the check order decides the verdict. One example is a virtualized U-mode request with the machine, hypervisor and supervisor bits all clear while load and store are both refused. The bench sweeps every combination of privilege, virtualization, operation, the three relevant enable bits and both permissions. In each enable vector it sets the bits that do not belong to the operation to the opposite value of the relevant bit, so a wrong bit select changes the verdict. Quiet cycles with changed inputs test that the response is held.

// File: rtl/cbo_pkg.sv
package cbo_pkg;
  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } cbo_op_e;

  typedef enum logic [1:0] {
    RES_GO     = 2'd0,
    RES_ILLEGAL = 2'd1,
    RES_VIRT   = 2'd2,
    RES_SFAULT = 2'd3
  } cbo_res_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int EN_W = 3;
endpackage

// File: rtl/cbo_env_gate.sv
module cbo_env_gate
  import cbo_pkg::*;
(
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic [1:0]      op,
  input  logic [EN_W-1:0] m_en,
  input  logic [EN_W-1:0] h_en,
  input  logic [EN_W-1:0] s_en,
  output logic            fault,
  output cbo_res_e        fault_code
);
  logic [1:0] sel;
  logic       mb, hb, sb;
  logic       below_m, le_s, below_s;

  always_comb begin
    case (op)
      OP_ZERO:  sel = 2'd0;
      OP_INVAL: sel = 2'd2;
      default:  sel = 2'd1;
    endcase
  end

  assign mb      = m_en[sel];
  assign hb      = h_en[sel];
  assign sb      = s_en[sel];
  assign below_m = (priv < PRIV_M);
  assign le_s    = (priv <= PRIV_S);
  assign below_s = (priv < PRIV_S);

  always_comb begin
    fault      = 1'b1;
    fault_code = RES_ILLEGAL;
    if (below_m && !mb) begin
      fault_code = RES_ILLEGAL;
    end else if (virt && ((le_s && !hb) || (below_s && !sb))) begin
      fault_code = RES_VIRT;
    end else if (below_s && !sb) begin
      fault_code = RES_ILLEGAL;
    end else begin
      fault      = 1'b0;
      fault_code = RES_GO;
    end
  end
endmodule

// File: rtl/cbo_access_rule.sv
module cbo_access_rule
  import cbo_pkg::*;
(
  input  logic [1:0] op,
  input  logic       load_ok,
  input  logic       store_ok,
  output cbo_res_e   verdict
);
  logic allowed;

  always_comb begin
    if (op == OP_ZERO) allowed = store_ok;
    else               allowed = load_ok || store_ok;
  end

  assign verdict = allowed ? RES_GO : RES_SFAULT;
endmodule

// File: rtl/cbo_block_align.sv
module cbo_block_align #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int OFS_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 0;

  generate
    if (OFS_W == 0) begin : g_byte
      assign addr_out = addr_in;
    end else begin : g_block
      assign addr_out = {addr_in[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/cbo_perm_gate.sv
module cbo_perm_gate
  import cbo_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic [1:0]        req_op,
  input  logic [2:0]        m_en,
  input  logic [2:0]        h_en,
  input  logic [2:0]        s_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              load_ok,
  input  logic              store_ok,
  output logic              rsp_valid,
  output logic [1:0]        rsp_result,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic              env_fault;
  cbo_res_e          env_code;
  cbo_res_e          acc_code;
  cbo_res_e          verdict;
  logic [ADDR_W-1:0] aligned;

  cbo_env_gate u_env (
    .priv       (req_priv),
    .virt       (req_virt),
    .op         (req_op),
    .m_en       (m_en),
    .h_en       (h_en),
    .s_en       (s_en),
    .fault      (env_fault),
    .fault_code (env_code)
  );

  cbo_access_rule u_acc (
    .op       (req_op),
    .load_ok  (load_ok),
    .store_ok (store_ok),
    .verdict  (acc_code)
  );

  cbo_block_align #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_align (
    .addr_in  (req_addr),
    .addr_out (aligned)
  );

  assign verdict = env_fault ? env_code : acc_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_GO;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_result <= verdict;
        rsp_addr   <= aligned;
      end
    end
  end
endmodule

// File: rtl/cbo_perm_gate_chk.sv
module cbo_perm_gate_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_priv,
  input logic              req_virt,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              load_ok,
  input logic              store_ok,
  input logic              rsp_valid,
  input logic [1:0]        rsp_result,
  input logic [ADDR_W-1:0] rsp_addr
);
  localparam int OFS_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;

  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && $stable(rsp_result) && $stable(rsp_addr)));

  a_r8_low_clear: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_addr[ADDR_W-1:OFS_W] == $past(req_addr[ADDR_W-1:OFS_W])));

  a_r4_mach_clean: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == 2'd3) |=> (rsp_result == 2'd0 || rsp_result == 2'd3));

  a_r3_virt_only: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_virt) |=> (rsp_result != 2'd2));

  a_r6_load_go: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == 2'd3 && req_op != 2'd0 && load_ok) |=> (rsp_result == 2'd0));

  a_r7_zero_store: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == 2'd3 && req_op == 2'd0) |=> (rsp_result == (store_ok_q ? 2'd0 : 2'd3)));

  logic store_ok_q;
  always_ff @(posedge clk) store_ok_q <= store_ok;
endmodule

bind cbo_perm_gate cbo_perm_gate_chk #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_priv   (req_priv),
  .req_virt   (req_virt),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .load_ok    (load_ok),
  .store_ok   (store_ok),
  .rsp_valid  (rsp_valid),
  .rsp_result (rsp_result),
  .rsp_addr   (rsp_addr)
);

// File: tb/cbo_perm_gate_tb.sv
module cbo_perm_gate_tb;
  localparam int AW = 32;
  localparam int BB = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_priv = '0;
  logic          req_virt = 1'b0;
  logic [1:0]    req_op = '0;
  logic [2:0]    m_en = '0, h_en = '0, s_en = '0;
  logic [AW-1:0] req_addr = '0;
  logic          load_ok = 1'b0, store_ok = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_result;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cbo_perm_gate #(.ADDR_W(AW), .BLOCK_BYTES(BB)) u_dut (.*);

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [1:0] p, input logic v, input logic [1:0] op,
                                       input logic mb, input logic hb, input logic sb,
                                       input logic ld, input logic st);
    int pl = int'(p);
    if (pl < 3 && !mb) return 2'd1;                                    // R2
    if (v && ((pl <= 1 && !hb) || (pl < 1 && !sb))) return 2'd2;       // R3
    if (pl < 1 && !sb) return 2'd1;                                    // R4
    if (op == 2'd0) return st ? 2'd0 : 2'd3;                           // R7
    return (ld || st) ? 2'd0 : 2'd3;                                   // R6
  endfunction

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 valid", {31'd0, rsp_valid}, 0);
    chk("R10 result", {30'd0, rsp_result}, 0);
    chk("R10 addr", rsp_addr, 0);

    for (int pi = 0; pi < 3; pi++) begin
      for (int v = 0; v < 2; v++) begin
        for (int op = 0; op < 4; op++) begin
          for (int e = 0; e < 8; e++) begin
            for (int ls = 0; ls < 4; ls++) begin
              logic [1:0] p;
              logic [2:0] oh;
              logic [AW-1:0] a;
              logic [1:0] ex;
              p  = (pi == 2) ? 2'd3 : 2'(pi);
              oh = (op == 0) ? 3'b001 : (op == 3) ? 3'b100 : 3'b010;   // R1 bit map
              a  = AW'(n) * 32'h9E3779B9;
              @(negedge clk);
              req_valid = 1'b1;
              req_priv  = p;
              req_virt  = v[0];
              req_op    = 2'(op);
              m_en      = e[0] ? oh : ~oh;
              h_en      = e[1] ? oh : ~oh;
              s_en      = e[2] ? oh : ~oh;
              load_ok   = ls[0];
              store_ok  = ls[1];
              req_addr  = a;
              ex = model(p, v[0], 2'(op), e[0], e[1], e[2], ls[0], ls[1]);
              @(negedge clk);
              req_valid = 1'b0;
              chk("R1-gating R5 verdict", {30'd0, rsp_result}, {30'd0, ex});
              chk("R9 valid pulse", {31'd0, rsp_valid}, 1);
              chk("R8 aligned addr", rsp_addr, a & ~AW'(BB - 1));
              if (n % 16 == 0) begin
                req_addr = ~a;
                load_ok  = ~load_ok;
                store_ok = ~store_ok;
                m_en     = ~m_en;
                @(negedge clk);
                chk("R9 hold result", {30'd0, rsp_result}, {30'd0, ex});
                chk("R9 hold addr", rsp_addr, a & ~AW'(BB - 1));
                chk("R9 valid low", {31'd0, rsp_valid}, 0);
              end
              n++;
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule